// File: doc/BRIEF.md
# PLL Feedback and Post-Divider Search Engine

This block picks divider settings for a clock synthesizer. A requested link clock in kHz is presented with a one-cycle start pulse, together with a profile select that chooses one of two reference-clock/pre-divider/feedback-range sets. The engine walks every feedback divider M in the profile's range, from low to high. For each M it walks the post divider P from 2 to 6. The synthesized frequency of each pair is computed with a bit-serial restoring divider, and the pair with the smallest absolute error against the request is kept.

When the search ends, the engine publishes the chosen M and P together with two packed words. The control word carries P as a single set bit. The divider word carries log2(N) and a 9-bit scrambled seed that stands for M. Requests outside the supported band are rejected at once and leave the published settings untouched. A one-cycle done pulse marks every completion, whether accepted or rejected.

Top module: `pll_div_search`

## Requirements
- R1: After reset, done and rangeErr are 0 and mOut, pOut, ctrlWord and divWord are all 0.
- R2: A request below 300000 or above 1150000 completes with done and rangeErr set to 1. mOut, pOut, ctrlWord and divWord keep their previous values.
- R3: Profile select 0 uses a 25000 kHz reference, N=1 and M in 62..92. Profile select 1 uses a 100000 kHz reference, N=4 and M in 70..96. P spans 2..6 in both. Each candidate frequency is floor(M*ref/(P*N)), and the result is a pair of minimum absolute error against the request.
- R4: Candidates are visited with M as the outer loop and P as the inner loop. A later candidate replaces the best one only when its error is strictly smaller, so among equal errors the earliest candidate wins.
- R5: The search ends as soon as a candidate's error is zero. A request matched exactly by the very first candidate completes within 40 cycles of start.
- R6: ctrlWord has exactly one bit set, at position PostDivBase + P - 2. PostDivBase is 20 by default.
- R7: divWord holds log2(N) at bit NShift, which is 12 by default. The value is 0 for profile select 0 and 2 for profile select 1.
- R8: divWord holds, at bit MShift (0 by default), the 9-bit seed for the chosen M. The seed comes from a 39-entry table indexed by M-62. The table begins 426, 469, 234, 373, 442 and ends 465, 488, 500, 506.
- R9: done is high for exactly one cycle per completion. All outputs already hold the new result in that cycle.
- R10: Inputs are captured only by a start while idle. A start during a search has no effect on its result and launches no further search.
- R11: An accepted request clears rangeErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search with the current inputs |
| profileSel | input | 1 | 0: profile with 25 MHz reference, 1: profile with 100 MHz reference |
| targetKhz | input | 21 | Requested clock in kHz |
| done | output | 1 | One-cycle completion pulse |
| rangeErr | output | 1 | Last request was out of band |
| mOut | output | 7 | Chosen feedback divider |
| pOut | output | 3 | Chosen post divider |
| ctrlWord | output | 32 | Packed control word with one-hot post divider |
| divWord | output | 32 | Packed divider word with N field and M seed |

## Verification
The bench builds the block with its default parameters: both profiles at their stated ranges, a 24-bit divider and the default field positions. A full search then costs a few thousand cycles, so about thirty requests fit in the run. These include a sweep across the whole accepted band for both profiles, both band edges and their neighbours just outside, an exact hit on the first candidate, an exact hit deep in the sweep, and an equal-error tie. Expected pairs, words and seeds come from a plain arithmetic search in the bench.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture request and set first candidate
    logic divGo;    // begin a division for the current candidate
    logic eval;     // quotient ready, compare with best
    logic first;    // this evaluation seeds the best candidate
    logic advance;  // move to next (M,P) pair
    logic commit;   // publish best result
    logic reject;   // request out of band
  } srchStrobe_t;

  localparam int SeedBase  = 62;
  localparam int SeedCount = 39;
  localparam int SeedW     = 9;

  function automatic logic [SeedW-1:0] mSeed(input logic [5:0] idx);
    case (idx)
      6'd0:  mSeed = 9'd426;  6'd1:  mSeed = 9'd469;  6'd2:  mSeed = 9'd234;
      6'd3:  mSeed = 9'd373;  6'd4:  mSeed = 9'd442;  6'd5:  mSeed = 9'd221;
      6'd6:  mSeed = 9'd110;  6'd7:  mSeed = 9'd311;  6'd8:  mSeed = 9'd411;
      6'd9:  mSeed = 9'd461;  6'd10: mSeed = 9'd486;  6'd11: mSeed = 9'd243;
      6'd12: mSeed = 9'd377;  6'd13: mSeed = 9'd188;  6'd14: mSeed = 9'd350;
      6'd15: mSeed = 9'd175;  6'd16: mSeed = 9'd343;  6'd17: mSeed = 9'd427;
      6'd18: mSeed = 9'd213;  6'd19: mSeed = 9'd106;  6'd20: mSeed = 9'd53;
      6'd21: mSeed = 9'd282;  6'd22: mSeed = 9'd397;  6'd23: mSeed = 9'd454;
      6'd24: mSeed = 9'd227;  6'd25: mSeed = 9'd113;  6'd26: mSeed = 9'd56;
      6'd27: mSeed = 9'd284;  6'd28: mSeed = 9'd142;  6'd29: mSeed = 9'd71;
      6'd30: mSeed = 9'd35;   6'd31: mSeed = 9'd273;  6'd32: mSeed = 9'd136;
      6'd33: mSeed = 9'd324;  6'd34: mSeed = 9'd418;  6'd35: mSeed = 9'd465;
      6'd36: mSeed = 9'd488;  6'd37: mSeed = 9'd500;  6'd38: mSeed = 9'd506;
      default: mSeed = '0;
    endcase
  endfunction

endpackage

// File: rtl/pllsrch_ctrl.sv
module pllsrch_ctrl
  import pllsrch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inRange,
  input  logic        divDone,
  input  logic        errZero,
  input  logic        lastCand,
  output srchStrobe_t strobe,
  output logic        done
);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_GO, S_DIV, S_STEP, S_FIN} srchState_t;

  srchState_t stateQ, stateD;
  logic       firstQ;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      S_IDLE: if (start) begin strobe.load = 1'b1; stateD = S_CHK; end
      S_CHK:  if (inRange) stateD = S_GO;
              else begin strobe.reject = 1'b1; stateD = S_IDLE; end
      S_GO:   begin strobe.divGo = 1'b1; stateD = S_DIV; end
      S_DIV:  if (divDone) begin
                strobe.eval  = 1'b1;
                strobe.first = firstQ;
                stateD = (errZero || lastCand) ? S_FIN : S_STEP;
              end
      S_STEP: begin strobe.advance = 1'b1; stateD = S_GO; end
      S_FIN:  begin strobe.commit = 1'b1; stateD = S_IDLE; end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      firstQ <= 1'b0;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= strobe.commit || strobe.reject;
      if (stateQ == S_CHK)   firstQ <= 1'b1;
      else if (strobe.eval)  firstQ <= 1'b0;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R10
  chk_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_CHK) |-> ($past(stateQ) == S_IDLE));
  // R5
  early_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eval && errZero) |=> (stateQ == S_FIN));

endmodule

// File: rtl/pllsrch_dp.sv
module pllsrch_dp
  import pllsrch_pkg::*;
#(
  parameter int TGT_W       = 21,
  parameter int TGT_MIN     = 300000,
  parameter int TGT_MAX     = 1150000,
  parameter int REF_A_KHZ   = 25000,
  parameter int N_A         = 1,
  parameter int M_MIN_A     = 62,
  parameter int M_MAX_A     = 92,
  parameter int REF_B_KHZ   = 100000,
  parameter int N_B         = 4,
  parameter int M_MIN_B     = 70,
  parameter int M_MAX_B     = 96,
  parameter int P_MIN       = 2,
  parameter int P_MAX       = 6,
  parameter int POST_BASE   = 20,
  parameter int N_SHIFT     = 12,
  parameter int M_SHIFT     = 0,
  parameter int CW          = 32,
  parameter int MW          = 7,
  parameter int PW          = 3,
  parameter int NUM_W       = 24,
  parameter int DEN_W       = 5
)(
  input  logic             clk,
  input  logic             rstN,
  input  srchStrobe_t      strobe,
  input  logic             profileSel,
  input  logic [TGT_W-1:0] targetKhz,
  output logic             inRange,
  output logic             divDone,
  output logic             errZero,
  output logic             lastCand,
  output logic             rangeErr,
  output logic [MW-1:0]    mOut,
  output logic [PW-1:0]    pOut,
  output logic [CW-1:0]    ctrlWord,
  output logic [CW-1:0]    divWord
);

  localparam int CNT_W  = $clog2(NUM_W);
  localparam int NLOG_A = $clog2(N_A);
  localparam int NLOG_B = $clog2(N_B);

  logic [TGT_W-1:0] tgtQ;
  logic             profQ;
  logic [MW-1:0]    curM, bestM, mMin, mMax;
  logic [PW-1:0]    curP, bestP;
  logic [NUM_W-1:0] bestErr, errNow, tgtExt, refK, numVal;
  logic [DEN_W-1:0] nVal, denVal;
  logic [3:0]       nLog;

  // divider state
  logic [NUM_W-1:0] numQ, quoQ;
  logic [DEN_W:0]   remQ, remSh;
  logic [CNT_W-1:0] cntQ;
  logic             divRun, remGe;

  assign mMin   = profQ ? MW'(M_MIN_B) : MW'(M_MIN_A);
  assign mMax   = profQ ? MW'(M_MAX_B) : MW'(M_MAX_A);
  assign refK   = profQ ? NUM_W'(REF_B_KHZ) : NUM_W'(REF_A_KHZ);
  assign nVal   = profQ ? DEN_W'(N_B) : DEN_W'(N_A);
  assign nLog   = profQ ? 4'(NLOG_B) : 4'(NLOG_A);
  assign numVal = NUM_W'(curM) * refK;
  assign denVal = DEN_W'(curP) * nVal;

  assign inRange  = (tgtQ >= TGT_W'(TGT_MIN)) && (tgtQ <= TGT_W'(TGT_MAX));
  assign lastCand = (curM == mMax) && (curP == PW'(P_MAX));
  assign tgtExt   = NUM_W'(tgtQ);
  assign errNow   = (tgtExt >= quoQ) ? (tgtExt - quoQ) : (quoQ - tgtExt);
  assign errZero  = (errNow == '0);

  assign remSh = {remQ[DEN_W-1:0], numQ[NUM_W-1]};
  assign remGe = (remSh >= {1'b0, denVal});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ <= '0; profQ <= 1'b0; curM <= '0; curP <= '0;
      numQ <= '0; quoQ <= '0; remQ <= '0; cntQ <= '0;
      divRun <= 1'b0; divDone <= 1'b0;
      bestErr <= '0; bestM <= '0; bestP <= '0;
      mOut <= '0; pOut <= '0; ctrlWord <= '0; divWord <= '0; rangeErr <= 1'b0;
    end else begin
      divDone <= divRun && (cntQ == CNT_W'(NUM_W-1));
      if (strobe.load) begin
        tgtQ  <= targetKhz;
        profQ <= profileSel;
        curM  <= profileSel ? MW'(M_MIN_B) : MW'(M_MIN_A);
        curP  <= PW'(P_MIN);
      end
      if (strobe.divGo) begin
        numQ <= numVal; quoQ <= '0; remQ <= '0; cntQ <= '0; divRun <= 1'b1;
      end else if (divRun) begin
        remQ <= remGe ? (remSh - {1'b0, denVal}) : remSh;
        quoQ <= {quoQ[NUM_W-2:0], remGe};
        numQ <= {numQ[NUM_W-2:0], 1'b0};
        if (cntQ == CNT_W'(NUM_W-1)) divRun <= 1'b0;
        else cntQ <= cntQ + 1'b1;
      end
      if (strobe.eval && (strobe.first || errNow < bestErr)) begin
        bestErr <= errNow; bestM <= curM; bestP <= curP;
      end
      if (strobe.advance) begin
        if (curP == PW'(P_MAX)) begin curP <= PW'(P_MIN); curM <= curM + 1'b1; end
        else curP <= curP + 1'b1;
      end
      if (strobe.commit) begin
        mOut     <= bestM;
        pOut     <= bestP;
        ctrlWord <= CW'(1) << (POST_BASE + int'(bestP) - P_MIN);
        divWord  <= (CW'(nLog) << N_SHIFT)
                  | (CW'(mSeed(6'(bestM - MW'(SeedBase)))) << M_SHIFT);
        rangeErr <= 1'b0;
      end
      if (strobe.reject) rangeErr <= 1'b1;
    end
  end

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reject |=> rangeErr && $stable(mOut) && $stable(pOut) && $stable(divWord));
  // R6
  onehot_p_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> ($countones(ctrlWord) == 1) && !rangeErr);
  // R3
  cand_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    divRun |-> (curM >= mMin) && (curM <= mMax) && (curP >= PW'(P_MIN)) && (curP <= PW'(P_MAX)));
  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eval && !strobe.first) |=> (bestErr <= $past(bestErr)));

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pllsrch_pkg::*;
#(
  parameter int TGT_W     = 21,
  parameter int TGT_MIN   = 300000,
  parameter int TGT_MAX   = 1150000,
  parameter int REF_A_KHZ = 25000,
  parameter int N_A       = 1,
  parameter int M_MIN_A   = 62,
  parameter int M_MAX_A   = 92,
  parameter int REF_B_KHZ = 100000,
  parameter int N_B       = 4,
  parameter int M_MIN_B   = 70,
  parameter int M_MAX_B   = 96,
  parameter int P_MIN     = 2,
  parameter int P_MAX     = 6,
  parameter int POST_BASE = 20,
  parameter int N_SHIFT   = 12,
  parameter int M_SHIFT   = 0,
  parameter int CW        = 32
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             profileSel,
  input  logic [TGT_W-1:0] targetKhz,
  output logic             done,
  output logic             rangeErr,
  output logic [MW-1:0]    mOut,
  output logic [PW-1:0]    pOut,
  output logic [CW-1:0]    ctrlWord,
  output logic [CW-1:0]    divWord
);

  localparam int M_TOP  = (M_MAX_A > M_MAX_B) ? M_MAX_A : M_MAX_B;
  localparam int N_TOP  = (N_A > N_B) ? N_A : N_B;
  localparam longint NUM_A = longint'(M_MAX_A) * REF_A_KHZ;
  localparam longint NUM_B = longint'(M_MAX_B) * REF_B_KHZ;
  localparam int MW     = $clog2(M_TOP + 1);
  localparam int PW     = $clog2(P_MAX + 1);
  localparam int NUM_W  = $clog2(((NUM_A > NUM_B) ? NUM_A : NUM_B) + 1);
  localparam int DEN_W  = $clog2(P_MAX * N_TOP + 1);

  srchStrobe_t strobe;
  logic inRange, divDone, errZero, lastCand;

  pllsrch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inRange(inRange), .divDone(divDone),
    .errZero(errZero), .lastCand(lastCand), .strobe(strobe), .done(done)
  );

  pllsrch_dp #(
    .TGT_W(TGT_W), .TGT_MIN(TGT_MIN), .TGT_MAX(TGT_MAX),
    .REF_A_KHZ(REF_A_KHZ), .N_A(N_A), .M_MIN_A(M_MIN_A), .M_MAX_A(M_MAX_A),
    .REF_B_KHZ(REF_B_KHZ), .N_B(N_B), .M_MIN_B(M_MIN_B), .M_MAX_B(M_MAX_B),
    .P_MIN(P_MIN), .P_MAX(P_MAX), .POST_BASE(POST_BASE), .N_SHIFT(N_SHIFT),
    .M_SHIFT(M_SHIFT), .CW(CW), .MW(MW), .PW(PW), .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .profileSel(profileSel),
    .targetKhz(targetKhz), .inRange(inRange), .divDone(divDone), .errZero(errZero),
    .lastCand(lastCand), .rangeErr(rangeErr), .mOut(mOut), .pOut(pOut),
    .ctrlWord(ctrlWord), .divWord(divWord)
  );

endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        profileSel = 1'b0;
  logic [20:0] targetKhz = '0;
  logic        done, rangeErr;
  logic [6:0]  mOut;
  logic [2:0]  pOut;
  logic [31:0] ctrlWord, divWord;

  int testsRun = 0;
  int testsFailed = 0;
  int doneCount = 0;

  int seedTab[39] = '{426, 469, 234, 373, 442, 221, 110, 311, 411, 461, 486, 243, 377,
                      188, 350, 175, 343, 427, 213, 106, 53, 282, 397, 454, 227, 113,
                      56, 284, 142, 71, 35, 273, 136, 324, 418, 465, 488, 500, 506};

  always #5 clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rstN(rstN), .start(start), .profileSel(profileSel),
    .targetKhz(targetKhz), .done(done), .rangeErr(rangeErr), .mOut(mOut),
    .pOut(pOut), .ctrlWord(ctrlWord), .divWord(divWord)
  );

  always @(posedge clk) if (rstN && done) doneCount++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic reference search
  task automatic model(input bit prof, input int tgt, output int bm, output int bp);
    int refk, n, mlo, mhi, best, d;
    refk = prof ? 100000 : 25000;
    n    = prof ? 4 : 1;
    mlo  = prof ? 70 : 62;
    mhi  = prof ? 96 : 92;
    bm = mlo; bp = 2;
    best = tgt - (mlo * refk) / (2 * n);
    if (best < 0) best = -best;
    for (int m = mlo; m <= mhi && best != 0; m++)
      for (int p = 2; p <= 6 && best != 0; p++) begin
        d = tgt - (m * refk) / (p * n);
        if (d < 0) d = -d;
        if (d < best) begin best = d; bm = m; bp = p; end
      end
  endtask

  task automatic launch(input bit prof, input int tgt);
    @(negedge clk);
    profileSel = prof;
    targetKhz  = 21'(tgt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 9000) begin
      @(negedge clk);
      lat++;
    end
    chk(done == 1'b1, "R9 done seen", longint'(done), 1);
  endtask

  task automatic checkResult(input bit prof, input int tgt);
    int bm, bp;
    model(prof, tgt, bm, bp);
    chk(mOut == 7'(bm), "R3 M choice", mOut, bm);
    chk(pOut == 3'(bp), "R4 P choice", pOut, bp);
    chk(ctrlWord == (32'd1 << (20 + bp - 2)), "R6 control word", ctrlWord, 32'd1 << (20 + bp - 2));
    chk(divWord == ((32'(prof ? 2 : 0) << 12) | 32'(seedTab[bm - 62])),
        "R7 R8 divider word", divWord, (longint'(prof ? 2 : 0) << 12) | seedTab[bm - 62]);
    chk(rangeErr == 1'b0, "R11 range flag clear", rangeErr, 0);
  endtask

  task automatic search(input bit prof, input int tgt);
    int lat;
    launch(prof, tgt);
    waitDone(lat);
    checkResult(prof, tgt);
    @(negedge clk);
    chk(done == 1'b0, "R9 single-cycle done", done, 0);
  endtask

  task automatic rejectCase(input bit prof, input int tgt);
    int lat;
    logic [6:0] m0; logic [2:0] p0; logic [31:0] c0, d0;
    m0 = mOut; p0 = pOut; c0 = ctrlWord; d0 = divWord;
    launch(prof, tgt);
    waitDone(lat);
    chk(rangeErr == 1'b1, "R2 range flag", rangeErr, 1);
    chk(mOut == m0 && pOut == p0, "R2 M/P kept", mOut, m0);
    chk(ctrlWord == c0 && divWord == d0, "R2 words kept", divWord, d0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int lat, dc0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 0 && rangeErr == 0, "R1 flags after reset", {done, rangeErr}, 0);
    chk(mOut == 0 && pOut == 0 && ctrlWord == 0 && divWord == 0, "R1 outputs after reset", divWord, 0);

    // R2 out-of-band requests with reset outputs
    rejectCase(1'b0, 299999);
    rejectCase(1'b1, 1150001);

    // R5 exact hit on first candidate: 62*25000/2
    launch(1'b0, 775000);
    waitDone(lat);
    chk(lat <= 40, "R5 early finish latency", lat, 40);
    checkResult(1'b0, 775000);

    // R4 tie: 781250 is equidistant from (62,2) and (63,2)
    search(1'b0, 781250);
    chk(mOut == 7'd62, "R4 tie keeps earlier", mOut, 62);

    // R5 exact hit deep in the sweep (80,4)
    search(1'b0, 500000);

    // band edges, both profiles
    search(1'b0, 300000);
    search(1'b1, 1150000);

    // R2 reject after a valid result keeps it
    rejectCase(1'b0, 0);
    rejectCase(1'b1, 2000000);
    search(1'b1, 300000);

    // R3 sweep across the band in both profiles
    for (int t = 337000; t < 1150000; t += 97000) begin
      search(1'b0, t);
      search(1'b1, t + 13);
    end

    // R10 start during a search is ignored
    dc0 = doneCount;
    launch(1'b0, 1000000);
    repeat (10) @(negedge clk);
    profileSel = 1'b1;
    targetKhz  = 21'd400000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    checkResult(1'b0, 1000000);
    repeat (100) @(negedge clk);
    chk(doneCount - dc0 == 1, "R10 no extra search", doneCount - dc0, 1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule